// File: doc/BRIEF.md
# Microcoded Memory Waveform Sequencer

This block produces the control waveforms of an external memory or peripheral from a table of 64 microinstructions. A requester asks for a transaction by naming its kind: single read, burst read, single write, burst write, refresh or exception. Each kind has a fixed entry point in the table, and the sequencer runs words from that entry until it reaches a word marked as the final one.

The block runs on a clock four times faster than the external bus clock. One pass of a microword lasts four fast cycles, one for each quarter of a bus clock. In each quarter the chip-select and byte-select pins take the level that the word gives for that quarter. Six general-purpose lines change only between the two halves of the bus clock. Flag bits in the word can repeat it up to three extra times, mark the two ends of a loop, advance a 5-bit low-address output, and pulse an acknowledge back to the requester. A wait input with a selectable active level holds the sequencer on its current word.

The table is loaded one word at a time through a write port while the sequencer is idle. After reset every word ends the routine at once and leaves every pin inactive.

Top module: `mwave_seq`

## Requirements
- R1: After reset, busy_o=0, cs_o=1, bs_o=1, gp_o=0, ack_o=0 and addr_o=0. Every table word resets to a final word with all chip-select and byte-select levels 1, so a routine run on an unprogrammed table lasts exactly 4 cycles and gives no acknowledge. While idle the pins keep these inactive levels.
- R2: A request (req_i=1 while idle) starts at table address 0x00 for kind 0 (single read), 0x08 for kind 1 (burst read), 0x18 for kind 2 (single write), 0x20 for kind 3 (burst write), 0x30 for kind 4 (refresh) and 0x3C for kind 5 (exception). Kind codes 6 and 7 are ignored.
- R3: A word is 26 bits wide: cs levels [25:22], bs levels [21:18], line-0 levels [17:16], lines 1..5 first half [15:11], lines 1..5 second half [10:6], repeat count [5:4], loop [3], next-address [2], acknowledge [1], final [0]. Bit q of the cs and bs fields drives cs_o and bs_o in quarter q (q=0..3). Quarter 0 of the entry word appears in the cycle after the edge that takes the request.
- R4: gp_o[0] is line 0 and takes bit 16 in quarters 0-1 and bit 17 in quarters 2-3. gp_o[5:1] take bits [15:11] in quarters 0-1 and bits [10:6] in quarters 2-3.
- R5: A repeat count of k makes the word run k+1 passes (4*(k+1) cycles) before the sequencer moves on.
- R6: The first loop-marked word opens a loop, and the next loop-marked word at a different address closes it. The body runs N times, where N comes from wr_loops_i for kinds 2 and 3 and from rd_loops_i for the other kinds. N=0 runs the body once.
- R7: addr_o loads req_addr_i when a request starts. It then increases by one, modulo 32, at the end of every completed pass of a word whose next-address bit is set, and it changes at no other time.
- R8: ack_o is 1 for one cycle, in quarter 3, of every completed pass of a word whose acknowledge bit is set.
- R9: After the last completed pass of a word whose final bit is set, busy_o falls and the pins return to their idle levels.
- R10: Wait is active when wait_i equals wait_pol_i. If wait is active in quarter 3, that pass does not count: the word runs again from quarter 0, no acknowledge is given, and addr_o and the repeat count stay as they are.
- R11: While busy, table writes and new requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, four cycles per bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transaction request, taken while idle |
| req_kind_i | input | 3 | Transaction kind code |
| req_addr_i | input | LA_W | Initial low address |
| rd_loops_i | input | LOOP_W | Loop count for read, refresh and exception kinds |
| wr_loops_i | input | LOOP_W | Loop count for write kinds |
| wait_i | input | 1 | Wait input |
| wait_pol_i | input | 1 | Level of wait_i that counts as active |
| mc_we_i | input | 1 | Table write strobe |
| mc_addr_i | input | 6 | Table write address |
| mc_data_i | input | 26 | Table write word |
| cs_o | output | 1 | Chip-select level |
| bs_o | output | 1 | Byte-select level |
| gp_o | output | 6 | General-purpose line levels, line 0 in bit 0 |
| addr_o | output | LA_W | Low address output |
| ack_o | output | 1 | Transfer acknowledge |
| busy_o | output | 1 | Routine in progress |

## Verification
The pins are combinational decodes of registered state. The bench therefore samples them mid-cycle and records each cycle from the first cycle after the request edge, which is quarter 0 of the entry word. Routine length, acknowledge positions (index 4j+3 of pass j) and the address at each pass boundary are then compared with counts computed from the repeat count, the loop count and the wait window. A routine has ended when busy_o first reads 0, exactly 4 cycles after the last pass began. A wait held over cycles 0 to k-1 therefore lengthens a single-pass routine by 4*floor(k/4) cycles.

// File: rtl/mwave_pkg.sv
package mwave_pkg;
  localparam int unsigned QUARTERS = 4;
  localparam int unsigned GP_LINES = 5;
  localparam int unsigned UC_DEPTH = 64;
  localparam int unsigned UADDR_W  = $clog2(UC_DEPTH);

  typedef struct packed {
    logic [QUARTERS-1:0] cs;
    logic [QUARTERS-1:0] bs;
    logic [1:0]          g0;
    logic [GP_LINES-1:0] g_lo;
    logic [GP_LINES-1:0] g_hi;
    logic [1:0]          redo;
    logic                loop;
    logic                nxt;
    logic                ack;
    logic                last;
  } uword_t;

  localparam int unsigned UWORD_W = $bits(uword_t);

  typedef enum logic [2:0] {
    K_RD_SINGLE = 3'd0,
    K_RD_BURST  = 3'd1,
    K_WR_SINGLE = 3'd2,
    K_WR_BURST  = 3'd3,
    K_REFRESH   = 3'd4,
    K_EXCEPT    = 3'd5
  } kind_e;

  localparam uword_t UWORD_IDLE = '{cs: '1, bs: '1, g0: '0, g_lo: '0, g_hi: '0,
                                    redo: '0, loop: 1'b0, nxt: 1'b0, ack: 1'b0,
                                    last: 1'b1};

  function automatic logic [UADDR_W-1:0] entry_of(input logic [2:0] kind);
    case (kind)
      3'd0:    return UADDR_W'(8'h00);
      3'd1:    return UADDR_W'(8'h08);
      3'd2:    return UADDR_W'(8'h18);
      3'd3:    return UADDR_W'(8'h20);
      3'd4:    return UADDR_W'(8'h30);
      default: return UADDR_W'(8'h3C);
    endcase
  endfunction
endpackage

// File: rtl/mwave_store.sv
module mwave_store
  import mwave_pkg::*;
#(
  parameter int unsigned DEPTH = UC_DEPTH,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  uword_t        wdata_i,
  input  logic [AW-1:0] raddr_i,
  output uword_t        rdata_o
);
  uword_t mem_q [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[w] <= UWORD_IDLE;
      else if (we_i && waddr_i == AW'(w)) mem_q[w] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mwave_phase.sv
module mwave_phase
  import mwave_pkg::*;
#(
  parameter int unsigned GP_N = GP_LINES,
  localparam int unsigned PH_W = $clog2(QUARTERS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                busy_i,
  input  logic [QUARTERS-1:0] cs_lv_i,
  input  logic [QUARTERS-1:0] bs_lv_i,
  input  logic [1:0]          g0_i,
  input  logic [GP_N-1:0]     glo_i,
  input  logic [GP_N-1:0]     ghi_i,
  output logic [PH_W-1:0]     ph_o,
  output logic                pass_end_o,
  output logic                cs_o,
  output logic                bs_o,
  output logic [GP_N:0]       gp_o
);
  logic [PH_W-1:0] ph_q;
  logic            late_half;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= '0;
    else if (start_i) ph_q <= '0;
    else if (busy_i)  ph_q <= ph_q + PH_W'(1);
  end

  assign late_half  = ph_q[PH_W-1];
  assign pass_end_o = busy_i && (ph_q == PH_W'(QUARTERS-1));
  assign ph_o       = ph_q;

  always_comb begin
    if (busy_i) begin
      cs_o = cs_lv_i[ph_q];
      bs_o = bs_lv_i[ph_q];
      gp_o = late_half ? {ghi_i, g0_i[1]} : {glo_i, g0_i[0]};
    end else begin
      cs_o = 1'b1;
      bs_o = 1'b1;
      gp_o = '0;
    end
  end
endmodule

// File: rtl/mwave_ctrl.sv
module mwave_ctrl
  import mwave_pkg::*;
#(
  parameter int unsigned LA_W   = 5,
  parameter int unsigned LOOP_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [2:0]         kind_i,
  input  logic [LA_W-1:0]    req_addr_i,
  input  logic [LOOP_W-1:0]  rd_loops_i,
  input  logic [LOOP_W-1:0]  wr_loops_i,
  input  logic               wait_i,
  input  logic               wait_pol_i,
  input  logic               pass_end_i,
  input  logic [1:0]         w_redo_i,
  input  logic               w_loop_i,
  input  logic               w_nxt_i,
  input  logic               w_ack_i,
  input  logic               w_last_i,
  output logic               start_o,
  output logic               busy_o,
  output logic [UADDR_W-1:0] pc_o,
  output logic [LA_W-1:0]    addr_o,
  output logic               ack_o
);
  logic               busy_q, lp_open_q, lp_wr_q;
  logic [UADDR_W-1:0] pc_q, lp_start_q;
  logic [LA_W-1:0]    addr_q;
  logic [1:0]         redo_q;
  logic [LOOP_W-1:0]  lp_left_q;
  logic               stall, step, kind_ok, redo_done, loop_close;

  assign stall      = (wait_i == wait_pol_i);
  assign kind_ok    = (kind_i <= 3'(K_EXCEPT));
  assign start_o    = !busy_q && req_i && kind_ok;
  assign step       = pass_end_i && !stall;
  assign redo_done  = (redo_q == w_redo_i);
  assign loop_close = w_loop_i && lp_open_q && (pc_q != lp_start_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      pc_q       <= '0;
      addr_q     <= '0;
      redo_q     <= '0;
      lp_open_q  <= 1'b0;
      lp_wr_q    <= 1'b0;
      lp_start_q <= '0;
      lp_left_q  <= '0;
    end else if (start_o) begin
      busy_q    <= 1'b1;
      pc_q      <= entry_of(kind_i);
      addr_q    <= req_addr_i;
      redo_q    <= '0;
      lp_open_q <= 1'b0;
      lp_wr_q   <= (kind_i == 3'(K_WR_SINGLE)) || (kind_i == 3'(K_WR_BURST));
    end else if (step) begin
      addr_q <= addr_q + LA_W'(w_nxt_i);
      if (!redo_done) begin
        redo_q <= redo_q + 2'd1;
      end else begin
        redo_q <= '0;
        if (w_last_i) begin
          busy_q <= 1'b0;
        end else if (loop_close) begin
          if (lp_left_q > LOOP_W'(1)) begin
            lp_left_q <= lp_left_q - LOOP_W'(1);
            pc_q      <= lp_start_q;
          end else begin
            lp_open_q <= 1'b0;
            pc_q      <= pc_q + UADDR_W'(1);
          end
        end else begin
          if (w_loop_i && !lp_open_q) begin
            lp_open_q  <= 1'b1;
            lp_start_q <= pc_q;
            lp_left_q  <= lp_wr_q ? wr_loops_i : rd_loops_i;
          end
          pc_q <= pc_q + UADDR_W'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign pc_o   = pc_q;
  assign addr_o = addr_q;
  assign ack_o  = step && w_ack_i;
endmodule

// File: rtl/mwave_seq.sv
module mwave_seq
  import mwave_pkg::*;
#(
  parameter int unsigned LA_W   = 5,
  parameter int unsigned LOOP_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [2:0]          req_kind_i,
  input  logic [LA_W-1:0]     req_addr_i,
  input  logic [LOOP_W-1:0]   rd_loops_i,
  input  logic [LOOP_W-1:0]   wr_loops_i,
  input  logic                wait_i,
  input  logic                wait_pol_i,
  input  logic                mc_we_i,
  input  logic [UADDR_W-1:0]  mc_addr_i,
  input  logic [UWORD_W-1:0]  mc_data_i,
  output logic                cs_o,
  output logic                bs_o,
  output logic [GP_LINES:0]   gp_o,
  output logic [LA_W-1:0]     addr_o,
  output logic                ack_o,
  output logic                busy_o
);
  localparam int unsigned PH_W = $clog2(QUARTERS);

  uword_t             cur_word, mc_word;
  logic [UADDR_W-1:0] pc;
  logic [PH_W-1:0]    ph_q;
  logic               start, busy, pass_end;

  assign mc_word = uword_t'(mc_data_i);
  assign busy_o  = busy;

  mwave_store #(.DEPTH(UC_DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mc_we_i && !busy),
    .waddr_i (mc_addr_i),
    .wdata_i (mc_word),
    .raddr_i (pc),
    .rdata_o (cur_word)
  );

  mwave_ctrl #(.LA_W(LA_W), .LOOP_W(LOOP_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .kind_i     (req_kind_i),
    .req_addr_i (req_addr_i),
    .rd_loops_i (rd_loops_i),
    .wr_loops_i (wr_loops_i),
    .wait_i     (wait_i),
    .wait_pol_i (wait_pol_i),
    .pass_end_i (pass_end),
    .w_redo_i   (cur_word.redo),
    .w_loop_i   (cur_word.loop),
    .w_nxt_i    (cur_word.nxt),
    .w_ack_i    (cur_word.ack),
    .w_last_i   (cur_word.last),
    .start_o    (start),
    .busy_o     (busy),
    .pc_o       (pc),
    .addr_o     (addr_o),
    .ack_o      (ack_o)
  );

  mwave_phase #(.GP_N(GP_LINES)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .busy_i     (busy),
    .cs_lv_i    (cur_word.cs),
    .bs_lv_i    (cur_word.bs),
    .g0_i       (cur_word.g0),
    .glo_i      (cur_word.g_lo),
    .ghi_i      (cur_word.g_hi),
    .ph_o       (ph_q),
    .pass_end_o (pass_end),
    .cs_o       (cs_o),
    .bs_o       (bs_o),
    .gp_o       (gp_o)
  );
endmodule

// File: rtl/mwave_seq_chk.sv
module mwave_seq_chk #(
  parameter int unsigned LA_W = 5,
  parameter int unsigned GP_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic [2:0]      req_kind_i,
  input logic            wait_i,
  input logic            wait_pol_i,
  input logic            busy_o,
  input logic            cs_o,
  input logic            bs_o,
  input logic [GP_W-1:0] gp_o,
  input logic [LA_W-1:0] addr_o,
  input logic            ack_o,
  input logic [1:0]      ph_i
);
  AST_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_o && bs_o && gp_o == '0 && !ack_o)); // R1

  AST_REQ_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && req_kind_i <= 3'd5) |=> (busy_o && ph_i == 2'd0)); // R2

  AST_GP_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ph_i[0]) |-> $stable(gp_o)); // R4

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ph_i != 2'd0) |-> $stable(addr_o)); // R7

  AST_ACK_QUARTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (busy_o && ph_i == 2'd3 && wait_i != wait_pol_i)); // R8

  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ph_i == 2'd3 && wait_i == wait_pol_i) |=>
      (busy_o && ph_i == 2'd0 && $stable(addr_o))); // R10
endmodule

bind mwave_seq mwave_seq_chk #(.LA_W(LA_W), .GP_W(GP_LINES + 1)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .req_kind_i (req_kind_i),
  .wait_i     (wait_i),
  .wait_pol_i (wait_pol_i),
  .busy_o     (busy_o),
  .cs_o       (cs_o),
  .bs_o       (bs_o),
  .gp_o       (gp_o),
  .addr_o     (addr_o),
  .ack_o      (ack_o),
  .ph_i       (ph_q)
);

// File: tb/mwave_seq_test.sv
`timescale 1ns/1ps
module mwave_seq_test;
  localparam int MAXC = 256;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  req_kind_i = '0;
  logic [4:0]  req_addr_i = '0;
  logic [3:0]  rd_loops_i = '0;
  logic [3:0]  wr_loops_i = '0;
  logic        wait_i = 1'b0;
  logic        wait_pol_i = 1'b1;
  logic        mc_we_i = 1'b0;
  logic [5:0]  mc_addr_i = '0;
  logic [25:0] mc_data_i = '0;
  logic        cs_o, bs_o, ack_o, busy_o;
  logic [5:0]  gp_o;
  logic [4:0]  addr_o;

  always #10 clk_i = ~clk_i;

  mwave_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_kind_i(req_kind_i),
    .req_addr_i(req_addr_i), .rd_loops_i(rd_loops_i), .wr_loops_i(wr_loops_i),
    .wait_i(wait_i), .wait_pol_i(wait_pol_i), .mc_we_i(mc_we_i),
    .mc_addr_i(mc_addr_i), .mc_data_i(mc_data_i), .cs_o(cs_o), .bs_o(bs_o),
    .gp_o(gp_o), .addr_o(addr_o), .ack_o(ack_o), .busy_o(busy_o)
  );

  int total = 0;
  int fails = 0;
  int n, acks;
  int w_lo = 0, w_hi = 0;
  logic        inj_on = 1'b0;
  int          inj_n = 0;
  logic [5:0]  inj_a = '0;
  logic [25:0] inj_d = '0;
  logic        rc_cs [MAXC];
  logic        rc_bs [MAXC];
  logic [5:0]  rc_gp [MAXC];
  logic [4:0]  rc_addr [MAXC];
  logic        rc_ack [MAXC];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [25:0] mk(input logic [3:0] cs, input logic [3:0] bs,
      input logic [1:0] g0, input logic [4:0] glo, input logic [4:0] ghi,
      input logic [1:0] redo, input logic lp, input logic nx, input logic ak,
      input logic ls);
    return {cs, bs, g0, glo, ghi, redo, lp, nx, ak, ls};
  endfunction

  function automatic logic wv(input int idx);
    return (idx >= w_lo && idx < w_hi) ? wait_pol_i : ~wait_pol_i;
  endfunction

  task automatic wr_uc(input logic [5:0] a, input logic [25:0] d);
    @(posedge clk_i); #5;
    mc_we_i = 1'b1; mc_addr_i = a; mc_data_i = d;
    @(posedge clk_i); #5;
    mc_we_i = 1'b0;
  endtask

  task automatic run(input logic [2:0] kind, input logic [4:0] a0);
    @(posedge clk_i); #5;
    req_i = 1'b1; req_kind_i = kind; req_addr_i = a0;
    @(posedge clk_i); #5;
    req_i = 1'b0; wait_i = wv(0);
    #5;
    n = 0; acks = 0;
    while (busy_o && n < MAXC) begin
      rc_cs[n] = cs_o; rc_bs[n] = bs_o; rc_gp[n] = gp_o;
      rc_addr[n] = addr_o; rc_ack[n] = ack_o;
      if (ack_o) acks++;
      n++;
      @(posedge clk_i); #5;
      mc_we_i = 1'b0; req_i = 1'b0;
      if (inj_on && n == inj_n) begin
        mc_we_i = 1'b1; mc_addr_i = inj_a; mc_data_i = inj_d;
        req_i = 1'b1; req_kind_i = 3'd0;
      end
      wait_i = wv(n);
      #5;
    end
    mc_we_i = 1'b0; req_i = 1'b0; wait_i = ~wait_pol_i;
  endtask

  function automatic logic [3:0] cs_word(input int base);
    return {rc_cs[base+3], rc_cs[base+2], rc_cs[base+1], rc_cs[base]};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    logic [5:0] starts [6];
    starts = '{6'h00, 6'h08, 6'h18, 6'h20, 6'h30, 6'h3C};
    #35 rst_ni = 1'b1;
    #10;
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 cs", cs_o, 1);
    chk("R1 bs", bs_o, 1);
    chk("R1 gp", gp_o, 0);
    chk("R1 ack", ack_o, 0);
    chk("R1 addr", addr_o, 0);
    run(3'd0, 5'd0);
    chk("R1 default length", n, 4);
    chk("R1 default cs", cs_word(0), 4'hF);
    chk("R1 default ack", acks, 0);
    chk("R1 idle cs", cs_o, 1);

    // R3 quarter sweep of cs/bs
    for (int p = 0; p < 16; p++) begin
      wr_uc(6'h00, mk(4'(p), ~4'(p), 2'b0, 5'b0, 5'b0, 2'd0, 0, 0, 0, 1));
      run(3'd0, 5'd0);
      chk("R9 single pass length", n, 4);
      for (int q = 0; q < 4; q++) begin
        chk("R3 cs quarter", rc_cs[q], (p >> q) & 1);
        chk("R3 bs quarter", rc_bs[q], ((p >> q) & 1) ^ 1);
      end
    end

    // R4 half-clock line sweep
    for (int t = 0; t < 8; t++) begin
      logic [1:0] g0; logic [4:0] glo, ghi;
      g0 = 2'(t); glo = 5'(t * 3 + 1); ghi = ~5'(t * 5 + 2);
      wr_uc(6'h18, mk(4'h0, 4'h0, g0, glo, ghi, 2'd0, 0, 0, 0, 1));
      run(3'd2, 5'd0);
      for (int q = 0; q < 4; q++)
        chk("R4 gp level", rc_gp[q], (q < 2) ? {glo, g0[0]} : {ghi, g0[1]});
    end

    // R2 entry points
    for (int k = 0; k < 6; k++)
      wr_uc(starts[k], mk(4'(k + 1), 4'hF, 2'b0, 5'b0, 5'b0, 2'd0, 0, 0, 0, 1));
    for (int k = 0; k < 6; k++) begin
      run(3'(k), 5'd0);
      chk("R2 entry word", cs_word(0), k + 1);
    end
    for (int k = 6; k < 8; k++) begin
      @(posedge clk_i); #5; req_i = 1'b1; req_kind_i = 3'(k);
      @(posedge clk_i); #5; req_i = 1'b0;
      #5 chk("R2 reserved kind ignored", busy_o, 0);
    end

    // R5 repeat, R7 address advance and wrap, R8 acknowledges
    for (int r = 0; r < 4; r++) begin
      for (int ai = 0; ai < 2; ai++) begin
        int a0;
        a0 = (ai == 0) ? 3 : 31;
        wr_uc(6'h08, mk(4'hE, 4'hD, 2'b0, 5'b0, 5'b0, 2'(r), 0, 1, 1, 1));
        run(3'd1, 5'(a0));
        chk("R5 repeat length", n, 4 * (r + 1));
        chk("R8 ack count", acks, r + 1);
        for (int j = 0; j <= r; j++) begin
          chk("R7 address per pass", rc_addr[4 * j], (a0 + j) % 32);
          chk("R8 ack in quarter 3", rc_ack[4 * j + 3], 1);
          chk("R8 no ack in quarter 0", rc_ack[4 * j], 0);
        end
      end
    end

    // R6 loops on write kind
    wr_uc(6'h20, mk(4'hF, 4'hF, 2'b0, 5'b0, 5'b0, 2'd0, 1, 0, 1, 0));
    wr_uc(6'h21, mk(4'hF, 4'hF, 2'b0, 5'b0, 5'b0, 2'd0, 1, 1, 1, 0));
    wr_uc(6'h22, mk(4'h5, 4'hF, 2'b0, 5'b0, 5'b0, 2'd0, 0, 0, 0, 1));
    for (int lc = 0; lc < 6; lc++) begin
      int it;
      it = (lc == 0) ? 1 : lc;
      wr_loops_i = 4'(lc); rd_loops_i = 4'(15 - lc);
      run(3'd3, 5'd0);
      chk("R6 write loop length", n, 4 * (2 * it + 1));
      chk("R8 loop acks", acks, 2 * it);
      chk("R9 final word", cs_word(n - 4), 4'h5);
      chk("R7 address after loop", rc_addr[n - 4], it);
    end
    // R6 loops on read kind use the read count
    wr_uc(6'h08, mk(4'hF, 4'hF, 2'b0, 5'b0, 5'b0, 2'd0, 1, 0, 1, 0));
    wr_uc(6'h09, mk(4'hF, 4'hF, 2'b0, 5'b0, 5'b0, 2'd0, 1, 1, 1, 0));
    wr_uc(6'h0A, mk(4'h5, 4'hF, 2'b0, 5'b0, 5'b0, 2'd0, 0, 0, 0, 1));
    rd_loops_i = 4'd3; wr_loops_i = 4'd1;
    run(3'd1, 5'd0);
    chk("R6 read loop length", n, 28);

    // R10 wait with both polarities
    wr_uc(6'h00, mk(4'h0, 4'h0, 2'b0, 5'b0, 5'b0, 2'd0, 0, 0, 1, 1));
    for (int pol = 0; pol < 2; pol++) begin
      int kl [5];
      kl = '{0, 3, 4, 7, 9};
      wait_pol_i = 1'(pol); wait_i = ~wait_pol_i;
      for (int i = 0; i < 5; i++) begin
        int s;
        w_lo = 0; w_hi = kl[i]; s = kl[i] / 4;
        run(3'd0, 5'd0);
        chk("R10 stalled length", n, 4 * (s + 1));
        chk("R10 single ack", acks, 1);
        chk("R10 ack after stall", rc_ack[4 * s + 3], 1);
      end
    end
    w_hi = 0; wait_pol_i = 1'b1; wait_i = 1'b0;

    // R11 writes and requests ignored while busy
    wr_loops_i = 4'd2;
    inj_on = 1'b1; inj_n = 2; inj_a = 6'h30;
    inj_d = mk(4'hA, 4'hF, 2'b0, 5'b0, 5'b0, 2'd0, 0, 0, 0, 1);
    run(3'd3, 5'd0);
    inj_on = 1'b0;
    chk("R11 request ignored while busy", n, 20);
    run(3'd4, 5'd0);
    chk("R11 write ignored while busy", cs_word(0), 4'h5);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule